// File: doc/BRIEF.md
# Multi-Port Cell Transmit Bus Slave

This block sits on the PHY side of a cell transmit bus of the UTOPIA Level 2 or Level 3 kind. A cell-layer master polls port addresses to learn which ports have room, selects one port, and then pushes a cell into it as a run of 32-bit words. The first word carries a start-of-cell strobe, and every word carries a parity bit. The block owns four ports. Each port has a transmit FIFO that holds four cells. A cell is 13 words long, or 14 words when the padded HEC word is configured in.

For every port the block drives a registered room flag. The flag drops once the FIFO cannot take another whole cell. It rises again only when the free space is greater than a programmable threshold. A polled flag echoes the room flag of whichever port address is on the bus. An output-enable goes with the polled flag: in Level 2 mode it is raised only when the address names one of this block's ports, and in Level 3 mode it is always raised. The line side drains complete cells through a simple word read port with first-word and last-word markers.

Top module: `cellbus_tx_slave`

## Requirements
- R1: While `tx_en` is low, the address sampled at each clock edge decides the port that the following enabled words go to. In Level 2 mode (`cfg_level3`=0) only address bits 4:0 are compared, so 0x22 names port 2. In Level 3 mode all 8 bits are compared. An address of 4 or more names no port, and words sent after such a selection are stored nowhere.
- R2: A cell is 13 words when `cfg_hec`=0 and 14 words when `cfg_hec`=1. A port holds at most 4 cells, and a cell becomes readable only after its last word has been written.
- R3: `rd_valid` is high while the port chosen by `rd_port` holds a complete cell. `rd_data` shows that cell's words in the order they were written. `rd_sop` marks word 0 and `rd_eop` marks the final word. Each clock edge with `rd_en` high advances by one word.
- R4: Each `dxa` bit is 1 out of reset. It is 0 from the edge after the one where its port has no free cell slot; a cell that is partly written counts as occupying a slot. It becomes 1 on the edge after free slots exceed `cfg_thresh`.
- R5: While a port's free slot count is between 1 and `cfg_thresh` inclusive, its `dxa` bit keeps its previous value.
- R6: One edge after an address is presented with `tx_en` low, `pxa` equals the `dxa` bit of the named port, or 0 if no port is named. `pxa_oe` is 1 when a port is named, and always 1 in Level 3 mode.
- R7: Parity is odd over the 32 data bits plus `tx_par`. A word with wrong parity sets that port's bit in `par_err`, which stays set until reset, and the word is still stored.
- R8: A start-of-cell arriving while a cell is partly written discards the partial cell and begins a new cell in the same slot. `soc_err_cnt` then increases by one, saturating at its maximum.
- R9: Enabled words without start-of-cell are discarded when no cell is in progress. A start-of-cell that finds the port full drops that whole cell, and the stored cells are left unchanged.
- R10: After reset all `dxa` bits are 1, and `pxa`, `pxa_oe`, `par_err`, `soc_err_cnt` and `rd_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bus clock; every input is sampled and every registered output changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_level3 | input | 1 | 1 selects Level 3 addressing and an always-driven polled flag |
| cfg_hec | input | 1 | 1 adds the padded HEC word, making a cell 14 words |
| cfg_thresh | input | 3 | Free-slot count that must be exceeded before a room flag rises |
| tx_addr | input | 8 | Port address for polling and selection |
| tx_en | input | 1 | High while data words are transferred; low for address phases |
| tx_data | input | 32 | Cell data word |
| tx_par | input | 1 | Odd parity bit for tx_data |
| tx_soc | input | 1 | Marks the first word of a cell |
| dxa | output | 4 | Per-port room flags |
| pxa | output | 1 | Polled room flag |
| pxa_oe | output | 1 | Drive enable for the polled flag pad |
| par_err | output | 4 | Sticky per-port parity error flags |
| soc_err_cnt | output | 8 | Saturating count of cells aborted by an early start-of-cell |
| rd_port | input | 2 | Port selected for line-side reading |
| rd_en | input | 1 | Pops one word from the selected port |
| rd_valid | output | 1 | Selected port holds a complete cell |
| rd_data | output | 32 | Current word of the selected port |
| rd_sop | output | 1 | Current word is the first of its cell |
| rd_eop | output | 1 | Current word is the last of its cell |

## Verification
`par_err`, `soc_err_cnt` and the slot state change on the same edge that takes the word in. `dxa` follows one edge later. `pxa` and `pxa_oe` are due one edge after the address is presented. The read outputs are combinational from the stored state and the `rd_port` value. The bench drives inputs on falling edges and samples on the next falling edge. For room flags, it waits one extra rising edge after the last word written or popped, so that each check lands in the cycle where the result is due. Expected flag values are derived by counting free slots against the threshold, and read data is rebuilt from the tag and word number that were used to form each word.

// File: rtl/cellbus_pkg.sv
package cellbus_pkg;

  // words in one cell for the current header option
  function automatic int unsigned cell_words(input logic with_hec, input int unsigned base_words);
    return with_hec ? base_words + 1 : base_words;
  endfunction

  // circular slot successor
  function automatic int unsigned slot_after(input int unsigned slot, input int unsigned n_slots);
    return (slot + 1 == n_slots) ? 0 : slot + 1;
  endfunction

  // address bits that take part in the compare for the active bus mode
  function automatic int unsigned fold_addr(input int unsigned addr, input logic level3,
                                            input int unsigned narrow_bits);
    return level3 ? addr : addr % (32'd1 << narrow_bits);
  endfunction

endpackage

// File: rtl/cb_poll_sel.sv
module cb_poll_sel
  import cellbus_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned L2_ADDR_W = 5,
  parameter int unsigned PI_W = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_level3,
  input  logic [ADDR_W-1:0]    tx_addr,
  input  logic                 tx_en,
  input  logic [NUM_PORTS-1:0] dxa,
  output logic                 sel_valid,
  output logic [PI_W-1:0]      sel_port,
  output logic                 pxa,
  output logic                 pxa_oe
);

  logic [ADDR_W-1:0] eff_addr;
  logic              addr_hit;
  logic [PI_W-1:0]   hit_port;

  assign eff_addr = ADDR_W'(fold_addr(32'(tx_addr), cfg_level3, L2_ADDR_W));
  assign addr_hit = eff_addr < ADDR_W'(NUM_PORTS);
  assign hit_port = eff_addr[PI_W-1:0];

  // selection follows the address while the data phase is idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_valid <= 1'b0;
      sel_port  <= '0;
    end else if (!tx_en) begin
      sel_valid <= addr_hit;
      sel_port  <= hit_port;
    end
  end

  // polled flag and its pad enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pxa    <= 1'b0;
      pxa_oe <= 1'b0;
    end else begin
      pxa    <= addr_hit & dxa[hit_port];
      pxa_oe <= addr_hit | cfg_level3;
    end
  end

  // R6
  l3_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_level3 |=> pxa_oe);

  // R6
  quiet_when_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pxa_oe |-> !pxa);

  // R1
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |=> ($stable(sel_port) && $stable(sel_valid)));

endmodule

// File: rtl/cb_port_fifo.sv
module cb_port_fifo
  import cellbus_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned FIFO_CELLS = 4,
  parameter int unsigned BASE_WORDS = 13,
  parameter int unsigned CNT_W = $clog2(FIFO_CELLS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_hec,
  input  logic [CNT_W-1:0]  cfg_thresh,
  input  logic              wr_en,
  input  logic              wr_soc,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_par,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_sop,
  output logic              rd_eop,
  output logic              dxa,
  output logic              par_err,
  output logic              soc_abort
);

  localparam int unsigned MAX_WORDS = BASE_WORDS + 1;
  localparam int unsigned DEPTH     = FIFO_CELLS * MAX_WORDS;
  localparam int unsigned SLOT_W    = (FIFO_CELLS > 1) ? $clog2(FIFO_CELLS) : 1;
  localparam int unsigned IDX_W     = $clog2(MAX_WORDS + 1);
  localparam int unsigned MA_W      = $clog2(DEPTH);

  function automatic logic parity_good(input logic [WORD_W-1:0] d, input logic p);
    return ^{d, p};
  endfunction

  function automatic logic [MA_W-1:0] mem_addr(input logic [SLOT_W-1:0] slot,
                                               input logic [IDX_W-1:0] idx);
    return MA_W'(32'(slot) * MAX_WORDS + 32'(idx));
  endfunction

  logic [WORD_W-1:0] mem [DEPTH];
  logic [SLOT_W-1:0] wr_slot, rd_slot;
  logic [IDX_W-1:0]  wr_idx, rd_idx, len_words, wr_pos;
  logic [CNT_W-1:0]  committed, used_cells, free_cells;
  logic              in_cell, dxa_q, perr_q;
  logic              soc_in, wr_fire, wr_last, rd_fire, rd_last;

  // slot accounting: a partly written cell holds its slot
  assign len_words  = IDX_W'(cell_words(cfg_hec, BASE_WORDS));
  assign used_cells = committed + CNT_W'(in_cell);
  assign free_cells = CNT_W'(FIFO_CELLS) - used_cells;

  // write side events
  assign soc_in    = wr_en & wr_soc;
  assign soc_abort = soc_in & in_cell;
  assign wr_fire   = wr_en & (in_cell | (wr_soc & (free_cells != '0)));
  assign wr_pos    = wr_soc ? '0 : wr_idx;
  assign wr_last   = wr_fire & (wr_pos == len_words - IDX_W'(1));

  always_ff @(posedge clk) begin
    if (wr_fire) mem[mem_addr(wr_slot, wr_pos)] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cell <= 1'b0;
      wr_idx  <= '0;
      wr_slot <= '0;
    end else if (wr_fire) begin
      if (wr_last) begin
        in_cell <= 1'b0;
        wr_idx  <= '0;
        wr_slot <= SLOT_W'(slot_after(32'(wr_slot), FIFO_CELLS));
      end else begin
        in_cell <= 1'b1;
        wr_idx  <= wr_pos + IDX_W'(1);
      end
    end
  end

  // read side
  assign rd_valid = committed != '0;
  assign rd_fire  = rd_en & rd_valid;
  assign rd_last  = rd_idx == len_words - IDX_W'(1);
  assign rd_data  = mem[mem_addr(rd_slot, rd_idx)];
  assign rd_sop   = rd_valid & (rd_idx == '0);
  assign rd_eop   = rd_valid & rd_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_idx  <= '0;
      rd_slot <= '0;
    end else if (rd_fire) begin
      if (rd_last) begin
        rd_idx  <= '0;
        rd_slot <= SLOT_W'(slot_after(32'(rd_slot), FIFO_CELLS));
      end else begin
        rd_idx <= rd_idx + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) committed <= '0;
    else committed <= committed + CNT_W'(wr_last) - CNT_W'(rd_fire & rd_last);
  end

  // room flag with hysteresis between full and the threshold
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dxa_q <= 1'b1;
    else if (free_cells == '0) dxa_q <= 1'b0;
    else if (free_cells > cfg_thresh) dxa_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) perr_q <= 1'b0;
    else if (wr_en && !parity_good(wr_data, wr_par)) perr_q <= 1'b1;
  end

  assign dxa     = dxa_q;
  assign par_err = perr_q;

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    used_cells <= CNT_W'(FIFO_CELLS));

  // R4
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_cells == '0) |=> !dxa_q);

  // R4
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dxa_q) |-> $past(free_cells > cfg_thresh));

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soc_abort |=> (in_cell && wr_idx == IDX_W'(1)));

  // R7
  perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perr_q |=> perr_q);

  // R9
  no_headless_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_cell && !wr_soc) |=> !in_cell);

endmodule

// File: rtl/cellbus_tx_slave.sv
module cellbus_tx_slave #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned FIFO_CELLS = 4,
  parameter int unsigned BASE_WORDS = 13,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned L2_ADDR_W = 5,
  parameter int unsigned ERR_W = 8,
  localparam int unsigned PI_W = $clog2(NUM_PORTS),
  localparam int unsigned CNT_W = $clog2(FIFO_CELLS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_level3,
  input  logic                 cfg_hec,
  input  logic [CNT_W-1:0]     cfg_thresh,
  input  logic [ADDR_W-1:0]    tx_addr,
  input  logic                 tx_en,
  input  logic [WORD_W-1:0]    tx_data,
  input  logic                 tx_par,
  input  logic                 tx_soc,
  output logic [NUM_PORTS-1:0] dxa,
  output logic                 pxa,
  output logic                 pxa_oe,
  output logic [NUM_PORTS-1:0] par_err,
  output logic [ERR_W-1:0]     soc_err_cnt,
  input  logic [PI_W-1:0]      rd_port,
  input  logic                 rd_en,
  output logic                 rd_valid,
  output logic [WORD_W-1:0]    rd_data,
  output logic                 rd_sop,
  output logic                 rd_eop
);

  logic                 sel_valid;
  logic [PI_W-1:0]      sel_port;
  logic [NUM_PORTS-1:0] wr_en_v, rd_en_v, abort_v;
  logic [NUM_PORTS-1:0] rd_valid_v, rd_sop_v, rd_eop_v;
  logic [WORD_W-1:0]    rd_data_a [NUM_PORTS];

  cb_poll_sel #(
    .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .L2_ADDR_W(L2_ADDR_W), .PI_W(PI_W)
  ) u_sel (
    .clk(clk), .rst_n(rst_n), .cfg_level3(cfg_level3), .tx_addr(tx_addr),
    .tx_en(tx_en), .dxa(dxa), .sel_valid(sel_valid), .sel_port(sel_port),
    .pxa(pxa), .pxa_oe(pxa_oe)
  );

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    assign wr_en_v[i] = tx_en & sel_valid & (sel_port == PI_W'(i));
    assign rd_en_v[i] = rd_en & (rd_port == PI_W'(i));

    cb_port_fifo #(
      .WORD_W(WORD_W), .FIFO_CELLS(FIFO_CELLS), .BASE_WORDS(BASE_WORDS), .CNT_W(CNT_W)
    ) u_fifo (
      .clk(clk), .rst_n(rst_n), .cfg_hec(cfg_hec), .cfg_thresh(cfg_thresh),
      .wr_en(wr_en_v[i]), .wr_soc(tx_soc), .wr_data(tx_data), .wr_par(tx_par),
      .rd_en(rd_en_v[i]), .rd_valid(rd_valid_v[i]), .rd_data(rd_data_a[i]),
      .rd_sop(rd_sop_v[i]), .rd_eop(rd_eop_v[i]), .dxa(dxa[i]),
      .par_err(par_err[i]), .soc_abort(abort_v[i])
    );
  end

  assign rd_valid = rd_valid_v[rd_port];
  assign rd_data  = rd_data_a[rd_port];
  assign rd_sop   = rd_sop_v[rd_port];
  assign rd_eop   = rd_eop_v[rd_port];

  // saturating count of aborted partial cells
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) soc_err_cnt <= '0;
    else if ((|abort_v) && (soc_err_cnt != '1)) soc_err_cnt <= soc_err_cnt + ERR_W'(1);
  end

  // R1
  one_port_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en_v));

  // R8
  err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|abort_v) && (soc_err_cnt != '1)) |=> (soc_err_cnt == $past(soc_err_cnt) + ERR_W'(1)));

endmodule

// File: tb/cellbus_tx_slave_test.sv
module cellbus_tx_slave_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_level3 = 1'b0, cfg_hec = 1'b0;
  logic [2:0]  cfg_thresh = '0;
  logic [7:0]  tx_addr = '0;
  logic        tx_en = 1'b0, tx_par = 1'b0, tx_soc = 1'b0;
  logic [31:0] tx_data = '0;
  logic [3:0]  dxa, par_err;
  logic        pxa, pxa_oe;
  logic [7:0]  soc_err_cnt;
  logic [1:0]  rd_port = '0;
  logic        rd_en = 1'b0;
  logic        rd_valid, rd_sop, rd_eop;
  logic [31:0] rd_data;

  int checks = 0;
  int fails = 0;

  cellbus_tx_slave uut (
    .clk(clk), .rst_n(rst_n), .cfg_level3(cfg_level3), .cfg_hec(cfg_hec),
    .cfg_thresh(cfg_thresh), .tx_addr(tx_addr), .tx_en(tx_en), .tx_data(tx_data),
    .tx_par(tx_par), .tx_soc(tx_soc), .dxa(dxa), .pxa(pxa), .pxa_oe(pxa_oe),
    .par_err(par_err), .soc_err_cnt(soc_err_cnt), .rd_port(rd_port), .rd_en(rd_en),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_sop(rd_sop), .rd_eop(rd_eop)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkw(input logic [15:0] tag, input int w);
    return {tag, 16'(w)};
  endfunction

  task automatic select(input logic [7:0] a);
    @(negedge clk);
    tx_en = 1'b0;
    tx_addr = a;
    @(posedge clk);
  endtask

  // n words, start-of-cell on word 0 when with_soc, parity wrong on word bad
  task automatic send(input logic [15:0] tag, input int n, input int bad = -1, input bit with_soc = 1'b1);
    for (int w = 0; w < n; w++) begin
      @(negedge clk);
      tx_en = 1'b1;
      tx_soc = with_soc && (w == 0);
      tx_data = mkw(tag, w);
      tx_par = ~(^tx_data) ^ (w == bad);
      @(posedge clk);
    end
    @(negedge clk);
    tx_en = 1'b0;
    tx_soc = 1'b0;
    @(posedge clk);
  endtask

  task automatic rdcell(input logic [1:0] p, input logic [15:0] tag, input int n, input string req);
    for (int w = 0; w < n; w++) begin
      @(negedge clk);
      rd_port = p;
      rd_en = 1'b1;
      #1;
      chk(req, {rd_valid, rd_sop, rd_eop, rd_data}, {1'b1, w == 0, w == n - 1, mkw(tag, w)});
      @(posedge clk);
    end
    @(negedge clk);
    rd_en = 1'b0;
    @(posedge clk);
  endtask

  task automatic check_empty(input logic [1:0] p, input string req);
    @(negedge clk);
    rd_port = p;
    #1;
    chk(req, rd_valid, 1'b0);
  endtask

  task automatic poll(input logic [7:0] a, input logic l3, input int full_port);
    int f;
    bit hit;
    f = l3 ? int'(a) : int'(a & 8'h1F);
    hit = f < 4;
    @(negedge clk);
    cfg_level3 = l3;
    tx_en = 1'b0;
    tx_addr = a;
    @(negedge clk);
    chk("R6 pxa_oe", pxa_oe, hit || l3);
    chk("R6 pxa", pxa, hit && (f != full_port));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] poll_list [7];
    bit flag;
    poll_list = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h21, 8'hFF};

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    chk("R10 dxa", dxa, 4'hF);
    chk("R10 pxa", {pxa, pxa_oe}, 2'b00);
    chk("R10 par_err", par_err, 4'h0);
    chk("R10 cnt", soc_err_cnt, 8'h00);
    for (int p = 0; p < 4; p++) check_empty(2'(p), "R10 rd_valid");

    // sweep: header option x port (threshold = port number)
    for (int h = 0; h < 2; h++) begin
      cfg_hec = 1'(h);
      for (int p = 0; p < 4; p++) begin
        int len;
        len = 13 + h;
        cfg_thresh = 3'(p);
        cfg_level3 = 1'b0;
        select(8'(p));
        for (int c = 0; c < 4; c++) send(16'(h * 256 + p * 16 + c), len);
        @(negedge clk);
        chk("R4 full", dxa, 4'hF & ~(4'b1 << p));
        for (int l = 0; l < 2; l++)
          for (int k = 0; k < 7; k++) poll(poll_list[k], 1'(l), p);
        cfg_level3 = 1'b0;
        flag = 1'b0;
        for (int k = 1; k <= 4; k++) begin
          rdcell(2'(p), 16'(h * 256 + p * 16 + k - 1), len, "R2 R3 cell data");
          @(negedge clk);
          if (k > p) flag = 1'b1;
          chk("R5 R4 hysteresis", dxa[p], flag);
        end
        check_empty(2'(p), "R3 drained");
      end
    end

    // R8 early start-of-cell
    cfg_hec = 1'b0;
    cfg_thresh = 3'd1;
    select(8'd1);
    send(16'h0A0A, 5);
    send(16'h0B0B, 13);
    @(negedge clk);
    chk("R8 count", soc_err_cnt, 8'd1);
    rdcell(2'd1, 16'h0B0B, 13, "R8 restarted cell");
    check_empty(2'd1, "R8 partial gone");
    send(16'h0C0C, 3);
    send(16'h0D0D, 13);
    @(negedge clk);
    chk("R8 count second", soc_err_cnt, 8'd2);
    rdcell(2'd1, 16'h0D0D, 13, "R8 second restart");

    // R9 headless words, then overflow
    select(8'd2);
    send(16'h0E0E, 4, -1, 1'b0);
    check_empty(2'd2, "R9 headless dropped");
    chk("R9 dxa untouched", dxa[2], 1'b1);
    for (int c = 0; c < 5; c++) send(16'h2000 + 16'(c), 13);
    for (int c = 0; c < 4; c++) rdcell(2'd2, 16'h2000 + 16'(c), 13, "R9 stored cells");
    check_empty(2'd2, "R9 fifth cell dropped");

    // R7 parity
    select(8'd3);
    send(16'h3030, 13, 4);
    @(negedge clk);
    chk("R7 flag", par_err, 4'b1000);
    rdcell(2'd3, 16'h3030, 13, "R7 word kept");
    send(16'h3131, 13);
    @(negedge clk);
    chk("R7 sticky", par_err, 4'b1000);
    rdcell(2'd3, 16'h3131, 13, "R7 later cell");

    // R1 address folding and foreign addresses
    cfg_level3 = 1'b0;
    select(8'h22);
    send(16'h4040, 13);
    rdcell(2'd2, 16'h4040, 13, "R1 level2 fold");
    select(8'h07);
    send(16'h4141, 13);
    for (int p = 0; p < 4; p++) check_empty(2'(p), "R1 foreign level2");
    cfg_level3 = 1'b1;
    select(8'h22);
    send(16'h4242, 13);
    for (int p = 0; p < 4; p++) check_empty(2'(p), "R1 foreign level3");
    select(8'h00);
    send(16'h4343, 13);
    rdcell(2'd0, 16'h4343, 13, "R1 level3 port");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule